// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing side of a simple UART. It decodes a 16-byte window of four 32-bit registers selected by address bits [3:2]. Incoming bytes from a receive path arrive on a byte-valid strobe and are queued in an eight-entry FIFO. Reading the receive data register pops that FIFO.

Every write to the transmit register sends the low byte straight out on a one-cycle byte-valid output. Transmission is modelled as instantaneous, so the transmitter always looks empty. A sticky pending flag is set by outbound writes and by a non-empty receive queue, and a read of the status register clears it. The interrupt output is that flag gated by an enable bit in the control register.

The serial shifter, the baud timing and error detection sit outside this block. Their status bits read as zero.

Top module: `uart_rf_top`

## Requirements
- R1: The register is picked by addr_i[3:2], and addr_i[1:0] is ignored. Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control.
- R2: Read data appears on rdata_o in the cycle after the read strobe and holds until the next read. A receive-data read returns the oldest queued byte in bits [7:0], with bits [31:8] at zero.
- R3: The receive FIFO stores up to 8 bytes and returns them in arrival order. rx_ready_o is low while 8 are stored, and a byte offered while 8 are stored is dropped.
- R4: A receive-data read while the FIFO is empty leaves the occupancy unchanged.
- R5: Status bit 0 is set when the FIFO is non-empty, and bit 1 when it holds 8 bytes. Bit 2 always reads 1. Bits 3, 5, 6, 7 and 31:8 read 0.
- R6: A control write stores the whole 32-bit value, which reads back unchanged. Control bit 1 empties the FIFO, and it wins over a byte arriving in the same cycle. Control bit 0 has no effect on the queue.
- R7: A transmit write pulses tx_valid_o for one cycle in the following cycle, with tx_byte_o equal to wdata_i[7:0]. The transmit register reads back the last written 32-bit value.
- R8: Status bit 4 (pending) is set after any transmit write and while the FIFO is non-empty. A status read returns the current value and then clears the bit, unless the FIFO is still non-empty.
- R9: irq_o equals pending AND control bit 4.
- R10: A write to the status register pulses wr_err_o in the following cycle and leaves the status contents unchanged.
- R11: After reset, status reads 0x04, control reads 0, irq_o is 0 and rx_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Single-cycle read strobe |
| wr_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 4 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| wr_err_o | output | 1 | Pulse on a write to the read-only status register |
| rx_byte_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_ready_o | output | 1 | FIFO can accept a byte |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | Transmit byte strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps the fill level from zero to nine bytes. At each level it checks the full and non-empty flags and ready, then drains the queue and compares every byte. An off-by-one in the full test would either drop the eighth byte or overwrite the oldest one. It also reads the empty queue, flushes the queue with a byte arriving in the same cycle, and writes the read-only status register. A pointer that moves on an empty read would corrupt later data, and a flush that loses to a push would leave a phantom byte. The pending flag is followed through transmit writes and status reads with the queue full and with it empty. A flag that does not clear, or that clears while data remains, shows up directly on irq_o.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  typedef enum logic [1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_RX_VALID = 0;
  localparam int unsigned ST_RX_FULL  = 1;
  localparam int unsigned ST_TX_EMPTY = 2;
  localparam int unsigned ST_TX_FULL  = 3;
  localparam int unsigned ST_PEND     = 4;

  localparam int unsigned CT_TX_RST = 0;
  localparam int unsigned CT_RX_RST = 1;
  localparam int unsigned CT_IRQ_EN = 4;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // storage is not reset: an empty read returns whatever sits at the head
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && wr_ptr_q == PTR_W'(i)) mem_q[i] <= data_i;
    end
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_wr_i,
  input  logic stat_rd_i,
  input  logic rx_nonempty_i,
  input  logic irq_en_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q && !stat_rd_i) || tx_wr_i || rx_nonempty_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && irq_en_i;
endmodule

// File: rtl/uart_rf_top.sv
module uart_rf_top
  import uart_rf_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_err_o,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              rx_rd, tx_wr, stat_rd, stat_wr, ctrl_wr;
  logic [DATA_W-1:0] ctrl_q, tx_q, status, rd_mux, rdata_q;
  logic [BYTE_W-1:0] head, tx_byte_q;
  logic [CNT_W-1:0]  count;
  logic              full, empty, pend, tx_valid_q, wr_err_q;
  logic              addr_unused;

  assign addr_unused = ^addr_i[1:0];
  assign sel     = reg_sel_e'(addr_i[ADDR_W-1:2]);
  assign rx_rd   = rd_i && sel == REG_RX;
  assign stat_rd = rd_i && sel == REG_STAT;
  assign tx_wr   = wr_i && sel == REG_TX;
  assign stat_wr = wr_i && sel == REG_STAT;
  assign ctrl_wr = wr_i && sel == REG_CTRL;

  uart_rf_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_valid_i),
    .data_i  (rx_byte_i),
    .pop_i   (rx_rd),
    .flush_i (ctrl_wr && wdata_i[CT_RX_RST]),
    .head_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  uart_rf_irq u_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_wr_i       (tx_wr),
    .stat_rd_i     (stat_rd),
    .rx_nonempty_i (!empty),
    .irq_en_i      (ctrl_q[CT_IRQ_EN]),
    .pend_o        (pend),
    .irq_o         (irq_o)
  );

  always_comb begin
    status              = '0;
    status[ST_RX_VALID] = !empty;
    status[ST_RX_FULL]  = full;
    status[ST_TX_EMPTY] = 1'b1;
    status[ST_TX_FULL]  = 1'b0;
    status[ST_PEND]     = pend;
  end

  always_comb begin
    unique case (sel)
      REG_RX:   rd_mux = {{(DATA_W-BYTE_W){1'b0}}, head};
      REG_TX:   rd_mux = tx_q;
      REG_STAT: rd_mux = status;
      default:  rd_mux = ctrl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      ctrl_q     <= '0;
      tx_q       <= '0;
      tx_byte_q  <= '0;
      tx_valid_q <= 1'b0;
      wr_err_q   <= 1'b0;
    end else begin
      if (rd_i)    rdata_q <= rd_mux;
      if (ctrl_wr) ctrl_q  <= wdata_i;
      if (tx_wr) begin
        tx_q      <= wdata_i;
        tx_byte_q <= wdata_i[BYTE_W-1:0];
      end
      tx_valid_q <= tx_wr;
      wr_err_q   <= stat_wr;
    end
  end

  assign rdata_o    = rdata_q;
  assign tx_byte_o  = tx_byte_q;
  assign tx_valid_o = tx_valid_q;
  assign wr_err_o   = wr_err_q;
  assign rx_ready_o = !full && (count <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              wr_err_o,
  input logic              rx_ready_o,
  input logic [BYTE_W-1:0] tx_byte_o,
  input logic              tx_valid_o,
  input logic              irq_o
);
  logic [1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_full_stays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ready_o && !(rd_i && idx == 2'd0) && !(wr_i && idx == 2'd3 && wdata_i[1]))
    |=> !rx_ready_o);

  p_flush_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx == 2'd3 && wdata_i[1]) |=> rx_ready_o);

  p_tx_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx == 2'd1) |=> (tx_valid_o && tx_byte_o == $past(wdata_i[BYTE_W-1:0])));

  p_tx_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx == 2'd1) |=> !tx_valid_o);

  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx == 2'd3 && !wdata_i[4]) |=> !irq_o);

  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx == 2'd2) |=> wr_err_o);

  p_err_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx == 2'd2) |=> !wr_err_o);
endmodule

bind uart_rf_top uart_rf_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .wr_err_o   (wr_err_o),
  .rx_ready_o (rx_ready_o),
  .tx_byte_o  (tx_byte_o),
  .tx_valid_o (tx_valid_o),
  .irq_o      (irq_o)
);

// File: tb/uart_rf_top_tb.sv
`timescale 1ns/1ps
module uart_rf_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wr_err_o;
  logic [7:0]  rx_byte_i = '0;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o;
  logic [7:0]  tx_byte_o;
  logic        tx_valid_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rf_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wr_err_o(wr_err_o),
    .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o),
    .tx_byte_o(tx_byte_o), .tx_valid_o(tx_valid_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    bus_rd(4'h8, d); chk("R11 status", d, 32'h04);
    bus_rd(4'hC, d); chk("R11 ctrl", d, 32'h0);
    chk("R11 irq", {31'b0, irq_o}, 32'h0);
    chk("R11 ready", {31'b0, rx_ready_o}, 32'h1);

    // R1 low address bits ignored
    for (int a = 8; a < 12; a++) begin
      bus_rd(4'(a), d); chk("R1 status alias", d & ~32'h10, 32'h04);
    end

    // R3 R4 R5 sweep fill level 0..9
    for (int n = 0; n <= 9; n++) begin
      int kept;
      kept = (n > 8) ? 8 : n;
      bus_wr(4'hC, 32'h2);
      for (int i = 0; i < n; i++) push(8'(n * 16 + i));
      @(negedge clk);
      bus_rd(4'h8, d);
      chk("R5 status level", d & ~32'h10, 32'h04 | (kept > 0 ? 32'h1 : 32'h0) | (kept == 8 ? 32'h2 : 32'h0));
      chk("R3 ready level", {31'b0, rx_ready_o}, (kept == 8) ? 32'h0 : 32'h1);
      for (int i = 0; i < kept; i++) begin
        bus_rd(4'(i & 3), d); chk("R2 R3 byte order", d, 32'((n * 16 + i) & 8'hFF));
      end
      bus_rd(4'h0, d);
      bus_rd(4'h8, d); chk("R4 empty read", d & ~32'h10, 32'h04);
    end

    // R4 empty read does not disturb later data
    push(8'hA7);
    bus_rd(4'h0, d); chk("R4 single", d, 32'hA7);
    bus_rd(4'h0, d);
    push(8'h3C);
    bus_rd(4'h0, d); chk("R4 after empty read", d, 32'h3C);

    // R6 flush wins over simultaneous byte; tx reset bit leaves queue alone
    push(8'h11);
    rx_valid_i = 1'b1; rx_byte_i = 8'h22;
    bus_wr(4'hC, 32'h2);
    rx_valid_i = 1'b0;
    bus_rd(4'h8, d); chk("R6 flush vs push", d & ~32'h10, 32'h04);
    push(8'h44); push(8'h55);
    bus_wr(4'hC, 32'hDEAD0001);
    bus_rd(4'hC, d); chk("R6 ctrl readback", d, 32'hDEAD0001);
    bus_rd(4'h0, d); chk("R6 tx reset no effect", d, 32'h44);
    bus_rd(4'h0, d); chk("R6 tx reset no effect", d, 32'h55);

    // R7 transmit
    bus_wr(4'h4, 32'hABCD125A);
    chk("R7 tx valid", {31'b0, tx_valid_o}, 32'h1);
    chk("R7 tx byte", {24'b0, tx_byte_o}, 32'h5A);
    @(negedge clk);
    chk("R7 one pulse", {31'b0, tx_valid_o}, 32'h0);
    bus_rd(4'h4, d); chk("R7 tx readback", d, 32'hABCD125A);

    // R10 status write
    bus_wr(4'h8, 32'hFFFFFFFF);
    chk("R10 err pulse", {31'b0, wr_err_o}, 32'h1);
    @(negedge clk);
    chk("R10 err clears", {31'b0, wr_err_o}, 32'h0);
    bus_rd(4'h8, d); chk("R10 status unchanged", d & ~32'h10, 32'h04);

    // R8 R9 pending and interrupt
    bus_wr(4'hC, 32'h10);
    bus_rd(4'h8, d);
    bus_rd(4'h8, d); chk("R8 cleared", d, 32'h04);
    chk("R9 irq low", {31'b0, irq_o}, 32'h0);
    bus_wr(4'h4, 32'h61);
    chk("R9 irq on tx", {31'b0, irq_o}, 32'h1);
    bus_rd(4'h8, d); chk("R8 set by tx", d, 32'h14);
    bus_rd(4'h8, d); chk("R8 clear by read", d, 32'h04);
    chk("R9 irq after clear", {31'b0, irq_o}, 32'h0);
    push(8'h77);
    @(negedge clk);
    bus_rd(4'h8, d); chk("R8 rx pending", d, 32'h15);
    bus_rd(4'h8, d); chk("R8 kept while nonempty", d, 32'h15);
    chk("R9 irq rx", {31'b0, irq_o}, 32'h1);
    bus_rd(4'h0, d); chk("R2 pop", d, 32'h77);
    bus_rd(4'h8, d); chk("R8 after drain", d, 32'h14);
    bus_rd(4'h8, d); chk("R8 drained clear", d, 32'h04);
    bus_wr(4'hC, 32'h0);
    bus_wr(4'h4, 32'h62);
    chk("R9 masked", {31'b0, irq_o}, 32'h0);
    bus_rd(4'h8, d); chk("R8 pending masked", d, 32'h14);

    done = 1'b1;
    finish_run();
  end
endmodule